// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block is the write front end of a byte-wide nonvolatile memory that looks like a static RAM to the host. The host drives active-low chip enable, output enable and write enable, a 15-bit address and an 8-bit data bus. All of these are sampled on the system clock. A qualified write strobe loads one byte into a 64-entry page buffer, and each buffer entry has its own valid flag. Upper address bits select the page and lower bits select the byte within it.

After the first byte, the block waits for further bytes. Each accepted byte restarts a byte-to-byte window. When the window expires, loading closes and a self-timed programming interval begins. During the first cycles of that interval the block walks the buffer and writes only the flagged bytes into a behavioural storage array. It then drops busy and pulses done.

Reads use the same strobes with output enable low, and they return array contents after two clock edges. The behavioural array holds `2**ARR_PAGE_W` pages. Page-number bits above that width take part in page matching but do not select storage.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy, done, page error and read data are all zero.
- R2: A write strobe starts on the first sampled cycle where chip enable and write enable are both low with output enable high, which is the later of the two falling edges. The address is latched from that cycle. The data written is the last value sampled while the strobe was active, before the earlier of the two rising edges.
- R3: A write enable pulse during which output enable is low, or chip enable is high, loads nothing and starts no programming.
- R4: Programming (busy high) begins exactly TIMEOUT_CYC+2 clock edges after the host deasserts the strobe of the last accepted byte, counting the edge that samples the deassertion. Every accepted byte restarts this window.
- R5: Address bits 14..6 form the page number and bits 5..0 form the byte offset. During a load, a byte with a different page number is dropped, does not restart the window, and sets the sticky page error output.
- R6: Bytes may arrive in any order. A byte loaded twice within one load period keeps its last value.
- R7: Programming writes only the offsets loaded in that period. All other bytes of the page keep their previous contents.
- R8: Busy stays high for exactly PROG_CYC cycles, chosen by PROG_SLOW_SEL between PROG_FAST_CYC and PROG_SLOW_CYC. When busy falls, done is high for exactly one cycle.
- R9: A write strobe that begins while busy is high is dropped and does not start a new load.
- R10: A read (chip enable low, output enable low, write enable high) presents the array byte at the sampled address on rd_data two clock edges after it is driven.
- R11: The page error output is cleared when the next page load begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in the low OFF_W bits |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | High during the programming interval |
| prog_done | output | 1 | One-cycle pulse when programming completes |
| page_err | output | 1 | Sticky flag: a byte from another page was dropped |

## Verification
Several properties are checked on every cycle. Buffer loads never occur while busy, and array writes happen only inside the programming interval. The load window counter never reaches its limit while loading. The latched address stays constant for the whole of a strobe. The page error rises only on a load attempt during loading, and done is a single pulse that follows the fall of busy. Other behaviours can only be shown by the bench scenarios, because they depend on values written and later read back. These are the last-value-wins rule, the preservation of unloaded bytes, the choice of which edge latches address and data, the exact window and busy lengths, and dropped strobes leaving the array untouched.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_strobe_qual.sv
// Samples host strobes, detects write strobe start/end, latches address and data.
module pw_strobe_qual #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output logic              ld_evt,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic              s_ce_n, s_oe_n, s_we_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              wr_act, wr_act_q, arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  // write qualified only with chip and write enable low and output enable high
  assign wr_act = !s_ce_n && !s_we_n && s_oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      arm_q    <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act && !wr_act_q) begin
        ld_addr <= s_addr;
        arm_q   <= !busy;
      end
      if (wr_act) ld_data <= s_din;
    end
  end

  assign ld_evt  = !wr_act && wr_act_q && arm_q;
  assign rd_en   = !s_ce_n && !s_oe_n && s_we_n;
  assign rd_addr = s_addr;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_act && wr_act_q) |=> $stable(ld_addr)); // R2
endmodule

// File: rtl/pw_page_buf.sv
// Page buffer: RAM-style data store plus per-offset valid flags, registered read.
module pw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_req,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_vld,
  output logic [OFF_W-1:0]  rd_off_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_data;
    rd_data <= mem[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rd_vld   <= 1'b0;
      rd_off_q <= '0;
    end else begin
      if (clr) valid <= '0;
      else if (wr_en) valid[wr_off] <= 1'b1;
      rd_vld   <= rd_req && valid[rd_off];
      rd_off_q <= rd_off;
    end
  end

  AST_NO_LOAD_DURING_WALK: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !wr_en); // R9
endmodule

// File: rtl/pw_array.sv
// Behavioural storage array, one write port and one registered read port.
module pw_array #(
  parameter int DATA_W = 8,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pw_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int OFF_W         = 6,
  parameter int ARR_PAGE_W    = 4,
  parameter int TIMEOUT_CYC   = 30000,
  parameter int PROG_FAST_CYC = 600000,
  parameter int PROG_SLOW_CYC = 2000000,
  parameter bit PROG_SLOW_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              prog_done,
  output logic              page_err
);
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PROG_CYC   = PROG_SLOW_SEL ? PROG_SLOW_CYC : PROG_FAST_CYC;
  localparam int TMR_W      = $clog2(TIMEOUT_CYC + 1);
  localparam int PCNT_W     = $clog2(PROG_CYC + 1);
  localparam int ARR_AW     = ARR_PAGE_W + OFF_W;

  pw_state_e         state;
  logic [TMR_W-1:0]  tmr;
  logic [PCNT_W-1:0] pcnt;
  logic [PAGE_W-1:0] pg_q;

  logic              ld_evt, rd_en;
  logic [ADDR_W-1:0] ld_addr, rd_addr;
  logic [DATA_W-1:0] ld_data, bw_data;
  logic [PAGE_W-1:0] ld_page;
  logic              page_hit, buf_we, buf_clr, walk_req, bw_vld;
  logic [OFF_W-1:0]  bw_off;

  pw_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy),
    .ld_evt(ld_evt), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  assign ld_page  = ld_addr[ADDR_W-1:OFF_W];
  assign page_hit = (ld_page == pg_q);
  assign buf_we   = ld_evt && ((state == ST_IDLE) || (state == ST_LOAD && page_hit));
  assign buf_clr  = (state == ST_PROG) && (pcnt == PCNT_W'(PROG_CYC - 1));
  assign walk_req = (state == ST_PROG) && (pcnt < PCNT_W'(PAGE_BYTES));
  assign busy     = (state == ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      pcnt      <= '0;
      pg_q      <= '0;
      page_err  <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      prog_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ld_evt) begin
            pg_q     <= ld_page;
            page_err <= 1'b0;
            tmr      <= '0;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ld_evt && page_hit) begin
            tmr <= '0;
          end else begin
            if (ld_evt) page_err <= 1'b1;
            if (tmr == TMR_W'(TIMEOUT_CYC - 1)) begin
              state <= ST_PROG;
              pcnt  <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (buf_clr) begin
            state     <= ST_IDLE;
            prog_done <= 1'b1;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pw_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(buf_we), .wr_off(ld_addr[OFF_W-1:0]), .wr_data(ld_data),
    .clr(buf_clr), .rd_req(walk_req), .rd_off(pcnt[OFF_W-1:0]),
    .rd_vld(bw_vld), .rd_off_q(bw_off), .rd_data(bw_data)
  );

  pw_array #(.DATA_W(DATA_W), .AW(ARR_AW)) u_arr (
    .clk(clk), .rst(rst),
    .we(bw_vld), .waddr({pg_q[ARR_PAGE_W-1:0], bw_off}), .wdata(bw_data),
    .re(rd_en), .raddr(rd_addr[ARR_AW-1:0]), .rdata(rd_data)
  );

  AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !buf_we); // R9
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |-> (tmr < TMR_W'(TIMEOUT_CYC))); // R4
  AST_COMMIT_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    bw_vld |-> busy); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> (!busy && $past(busy))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> !prog_done); // R8
  AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(page_err) |-> $past(ld_evt && state == ST_LOAD)); // R5
endmodule

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
  localparam int T  = 40;
  localparam int PF = 100;
  localparam int PS = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  rd_data;
  logic        busy, prog_done, page_err;

  int checks = 0, errors = 0, cyc = 0, mark = 0;
  logic [7:0]  exp_q [$];
  logic [14:0] adr_q [$];
  string       req_q [$];
  logic issue = 1'b0, p1 = 1'b0, p2 = 1'b0;

  always #2.5 clk = ~clk;

  page_write_ctrl #(
    .TIMEOUT_CYC(T), .PROG_FAST_CYC(PF), .PROG_SLOW_CYC(PS), .PROG_SLOW_SEL(1'b0)
  ) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rd_data(rd_data),
    .busy(busy), .prog_done(prog_done), .page_err(page_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p1  <= issue;
    p2  <= p1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: read data appears two edges after the request
  always @(negedge clk) begin
    if (p2) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual read with empty queue expected none");
      end else begin
        logic [7:0] e;
        logic [14:0] a;
        string r;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: addr %0h actual %0h expected %0h", r, a, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    exp_q.push_back(e); adr_q.push_back(a); req_q.push_back(req);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; mark = cyc;
  endtask

  task automatic wait_busy(input string req, input int exp_lat);
    int g;
    g = 0;
    while (!busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
    chk(req, cyc - mark, exp_lat);
  endtask

  task automatic busy_len();
    int n;
    n = 0;
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
    chk("R8 busy length", n, PF);
    chk("R8 done pulse", int'(prog_done), 1);
    @(negedge clk);
    chk("R8 done single", int'(prog_done), 0);
  endtask

  task automatic quiet(input int n, input string req);
    int hi;
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk(req, hi, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(prog_done), 0);
    chk("R1 page_err", int'(page_err), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rd(15'h040, 8'h00, "R10 blank read");

    // R6 out of order with overwrite, page 1
    wr(15'h045, 8'h11);
    wr(15'h042, 8'h22);
    wr(15'h045, 8'h33);
    wr(15'h07F, 8'h44);
    wr(15'h040, 8'h55);
    wait_busy("R4 window latency", T + 2);
    busy_len();
    rd(15'h040, 8'h55, "R6 offset 0");
    rd(15'h041, 8'h00, "R7 untouched offset");
    rd(15'h042, 8'h22, "R6 offset 2");
    rd(15'h045, 8'h33, "R6 last value wins");
    rd(15'h07F, 8'h44, "R5 top offset");

    // R7 partial reload of same page
    wr(15'h041, 8'h66);
    wait_busy("R4 single byte latency", T + 2);
    busy_len();
    rd(15'h040, 8'h55, "R7 keep offset 0");
    rd(15'h041, 8'h66, "R7 new offset 1");
    rd(15'h042, 8'h22, "R7 keep offset 2");

    // R3 inhibited strobes
    @(negedge clk);
    addr = 15'h043; din = 8'hEE; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    addr = 15'h044; ce_n = 1'b1; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    quiet(T + 10, "R3 no programming");
    rd(15'h043, 8'h00, "R3 oe low ignored");
    rd(15'h044, 8'h00, "R3 ce high ignored");

    // R2 later falling edge latches address, last sampled data kept
    @(negedge clk);
    addr = 15'h0C1; din = 8'h10; we_n = 1'b0; ce_n = 1'b1;
    @(negedge clk);
    addr = 15'h0C2;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    addr = 15'h0C3; din = 8'h20;
    @(negedge clk);
    din = 8'h30;
    @(negedge clk);
    we_n = 1'b1; din = 8'h99; mark = cyc;
    @(negedge clk);
    ce_n = 1'b1;
    wait_busy("R4 latency after write enable rise", T + 2);
    busy_len();
    rd(15'h0C2, 8'h30, "R2 latched address and data");
    rd(15'h0C1, 8'h00, "R2 early address unused");
    rd(15'h0C3, 8'h00, "R2 late address unused");

    // R5 page mismatch dropped, window not restarted, sticky error
    wr(15'h103, 8'hA1);
    begin
      int m1;
      m1 = mark;
      repeat (5) @(negedge clk);
      wr(15'h143, 8'hB2);
      @(negedge clk);
      @(negedge clk);
      chk("R5 page error set", int'(page_err), 1);
      mark = m1;
    end
    wait_busy("R5 window not restarted", T + 2);
    busy_len();
    chk("R5 page error sticky", int'(page_err), 1);
    rd(15'h103, 8'hA1, "R5 first page written");
    rd(15'h143, 8'h00, "R5 other page dropped");

    // R11 clear on new load, R4 window restart, R9 busy strobes dropped
    wr(15'h181, 8'h01);
    repeat (3) @(negedge clk);
    chk("R11 page error cleared", int'(page_err), 0);
    quiet(T - 8, "R4 no early programming");
    wr(15'h182, 8'h02);
    wait_busy("R4 window restarted", T + 2);
    wr(15'h183, 8'h03);
    while (busy) @(negedge clk);
    quiet(T + 10, "R9 busy strobe starts nothing");
    rd(15'h181, 8'h01, "R4 first byte kept");
    rd(15'h182, 8'h02, "R4 second byte written");
    rd(15'h183, 8'h00, "R9 busy strobe dropped");

    repeat (5) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule